// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Read Engine

This block is the slave side of a two-wire serial memory holding 8192 bytes. It watches a serial clock line and a serial data line that are both sampled on the system clock. It recognises bus start and stop conditions and answers to a seven-bit device identity. It also keeps a 13-bit address counter, which the master loads with a two-byte word address. It drives the data line only by pulling it low, shown here as an output-enable. Read data comes from a behavioural array whose contents are a fixed function of the address, so the array needs no storage.

A master reads from any location in two steps. First it sends a write frame that carries only the word address, called a dummy write. It then sends a repeated start and a read frame. The read frame returns the byte at the counter, and the counter steps forward after each byte. While the master acknowledges, bytes keep flowing. A master non-acknowledge followed by a stop ends the read. A write frame never changes the array; it only loads the counter.

Top module: `eeprom_serial_slave`

## Requirements
- R1: After reset the data-line enable is low, and it stays low until an address byte matches.
- R2: The first byte after a start is taken MSB first: bits 7..4 must be 1010, bits 3..1 must equal the strap inputs (strap bit 2 first), and bit 0 is read (1) or write (0). A matching byte gets an acknowledge: the slave holds the line low through the ninth clock.
- R3: If the address byte does not match, the slave gives no acknowledge and ignores every bit until the next start. This holds even if later bytes would match.
- R4: In a write frame, the slave acknowledges both word-address bytes. In the first byte, bits 7..5 are ignored and bits 4..0 become counter bits 12..8. The second byte becomes counter bits 7..0.
- R5: A read frame returns the byte at the counter as D7 first and D0 last, with each bit valid for the whole high phase of the clock. The byte at address a is a[7:0] XOR {000, a[12:8]} XOR 0x5A.
- R6: A read without a new word address starts at the counter, and the counter advances by one after each byte is sent.
- R7: When the master acknowledges a data byte, the slave sends the byte at the next address. The counter wraps from 0x1FFF to 0x0000.
- R8: A start or a stop in the middle of a frame abandons it. The enable is released, and a partly received word address leaves the counter unchanged.
- R9: The enable changes only while the clock line is low. The acknowledge is released after the ninth falling clock edge.
- R10: A data byte that follows the word address in a write frame is not acknowledged and does not change the array. The counter holds the loaded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk_i | input | 1 | Serial clock line level |
| bus_dat_i | input | 1 | Serial data line level as seen on the wire |
| sel_strap_i | input | 3 | Strap value that selects the lower three bits of the device identity |
| bus_dat_oe_o | output | 1 | Pull the data line low when high |

## Verification
The assertions assume a legal bus. The master changes the data line only while the clock is low, except when it forms a start or a stop. It never makes a start or stop while the slave is pulling the line low. Each clock phase lasts several system clocks, so every edge passes through the synchronizer before the next one arrives. The bench master models the line as a wired-AND, holds each clock phase for twelve system clocks, and moves its data a quarter-bit after each falling edge. It issues starts and stops only in bit slots where the slave has released the line.

// File: rtl/eeprom_slave_pkg.sv
package eeprom_slave_pkg;
    localparam int unsigned MEM_AW  = 13;
    localparam int unsigned HI_W    = MEM_AW - 8;
    localparam int unsigned BITS    = 8;
    localparam int unsigned CNT_W   = $clog2(BITS + 1);
    localparam logic [7:0]  PAT_KEY = 8'h5A;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK
    } bus_st_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_WHI,
        PH_WLO
    } rx_phase_e;

    typedef enum logic [1:0] {
        AK_WHI,
        AK_WLO,
        AK_LOAD,
        AK_TX
    } ack_next_e;

    typedef struct packed {
        bus_st_e            st;
        rx_phase_e          phase;
        ack_next_e          ack_to;
        logic [CNT_W-1:0]   cnt;
        logic [7:0]         sh;
        logic [HI_W-1:0]    hi;
        logic [MEM_AW-1:0]  addr;
        logic               oe;
        logic               mack;
    } eng_t;
endpackage

// File: rtl/line_sync_edge.sv
module line_sync_edge #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_line_i,
    input  logic dat_line_i,
    output logic clk_s_o,
    output logic dat_s_o,
    output logic clk_rise_o,
    output logic clk_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int unsigned LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] sync_v;
    logic [LINES-1:0] prev_q;

    assign raw = {dat_line_i, clk_line_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [DEPTH-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[DEPTH-2:0], raw[g]};
        end
        assign sync_v[g] = chain_q[DEPTH-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= sync_v;
    end

    assign clk_s_o    = sync_v[0];
    assign dat_s_o    = sync_v[1];
    assign clk_rise_o = sync_v[0] & ~prev_q[0];
    assign clk_fall_o = ~sync_v[0] & prev_q[0];
    assign start_o    = sync_v[0] & prev_q[0] & prev_q[1] & ~sync_v[1];
    assign stop_o     = sync_v[0] & prev_q[0] & ~prev_q[1] & sync_v[1];
endmodule

// File: rtl/eeprom_pattern_rom.sv
module eeprom_pattern_rom
    import eeprom_slave_pkg::*;
(
    input  logic [MEM_AW-1:0] addr_i,
    output logic [7:0]        data_o
);
    localparam int unsigned PAD = 8 - HI_W;

    logic [7:0] hi_ext;

    assign hi_ext = {{PAD{1'b0}}, addr_i[MEM_AW-1:8]};
    assign data_o = addr_i[7:0] ^ hi_ext ^ PAT_KEY;
endmodule

// File: rtl/eeprom_serial_slave.sv
module eeprom_serial_slave
    import eeprom_slave_pkg::*;
#(
    parameter logic [3:0]  DEV_CODE   = 4'b1010,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_clk_i,
    input  logic       bus_dat_i,
    input  logic [2:0] sel_strap_i,
    output logic       bus_dat_oe_o
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
    logic [7:0] rom_q;
    logic [MEM_AW-1:0] addr_cnt;
    eng_t q, d;

    line_sync_edge #(.DEPTH(SYNC_DEPTH)) i_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_line_i (bus_clk_i),
        .dat_line_i (bus_dat_i),
        .clk_s_o    (scl_s),
        .dat_s_o    (sda_s),
        .clk_rise_o (scl_rise),
        .clk_fall_o (scl_fall),
        .start_o    (start_c),
        .stop_o     (stop_c)
    );

    eeprom_pattern_rom i_rom (
        .addr_i (q.addr),
        .data_o (rom_q)
    );

    always_comb begin
        d = q;
        if (start_c) begin
            d.st    = ST_RX;
            d.phase = PH_DEV;
            d.cnt   = '0;
            d.oe    = 1'b0;
        end else if (stop_c) begin
            d.st  = ST_IDLE;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else begin
            unique case (q.st)
                ST_RX: begin
                    if (scl_rise && (q.cnt != CNT_W'(BITS))) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && (q.cnt == CNT_W'(BITS))) begin
                        d.cnt = '0;
                        unique case (q.phase)
                            PH_DEV: begin
                                if (q.sh[7:1] == {DEV_CODE, sel_strap_i}) begin
                                    d.st     = ST_ACK;
                                    d.oe     = 1'b1;
                                    d.ack_to = q.sh[0] ? AK_TX : AK_WHI;
                                end else begin
                                    d.st = ST_IDLE;
                                end
                            end
                            PH_WHI: begin
                                d.hi     = q.sh[HI_W-1:0];
                                d.st     = ST_ACK;
                                d.oe     = 1'b1;
                                d.ack_to = AK_WLO;
                            end
                            default: begin
                                d.st     = ST_ACK;
                                d.oe     = 1'b1;
                                d.ack_to = AK_LOAD;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.oe = 1'b0;
                        unique case (q.ack_to)
                            AK_WHI: begin
                                d.st    = ST_RX;
                                d.phase = PH_WHI;
                            end
                            AK_WLO: begin
                                d.st    = ST_RX;
                                d.phase = PH_WLO;
                            end
                            AK_LOAD: begin
                                d.addr = {q.hi, q.sh};
                                d.st   = ST_IDLE;
                            end
                            default: begin
                                d.sh   = rom_q;
                                d.oe   = ~rom_q[7];
                                d.addr = q.addr + 1'b1;
                                d.st   = ST_TX;
                                d.cnt  = '0;
                            end
                        endcase
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == CNT_W'(BITS - 1)) begin
                            d.st   = ST_RACK;
                            d.oe   = 1'b0;
                            d.mack = 1'b0;
                        end else begin
                            d.sh  = {q.sh[6:0], 1'b0};
                            d.oe  = ~q.sh[6];
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.sh   = rom_q;
                            d.oe   = ~rom_q[7];
                            d.addr = q.addr + 1'b1;
                            d.st   = ST_TX;
                            d.cnt  = '0;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, phase: PH_DEV, ack_to: AK_WHI, cnt: '0,
                   sh: '0, hi: '0, addr: '0, oe: 1'b0, mack: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign addr_cnt     = q.addr;
    assign bus_dat_oe_o = q.oe;
endmodule

// File: rtl/eeprom_slave_checker.sv
module eeprom_slave_checker
    import eeprom_slave_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              scl_fall,
    input logic              start_c,
    input logic              stop_c,
    input logic              oe,
    input logic [MEM_AW-1:0] addr
);
    p_oe_moves_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(oe) |-> !scl_s);

    p_start_releases_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_c |=> !oe);

    p_stop_releases_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> !oe);

    p_addr_moves_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(addr) |-> $past(scl_fall));
endmodule

bind eeprom_serial_slave eeprom_slave_checker i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .scl_fall (scl_fall),
    .start_c  (start_c),
    .stop_c   (stop_c),
    .oe       (bus_dat_oe_o),
    .addr     (addr_cnt)
);

// File: tb/test_eeprom_serial_slave.sv
module test_eeprom_serial_slave;
    localparam int Q = 6;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic oe;
    logic sda_bus;

    int checks = 0;
    int errors = 0;
    logic [12:0] exp_addr = '0;

    string exp_tag_q[$];
    int    exp_val_q[$];
    int    act_q[$];

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~oe;

    eeprom_serial_slave i_eeprom_serial_slave (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_clk_i    (scl_m),
        .bus_dat_i    (sda_bus),
        .sel_strap_i  (STRAP),
        .bus_dat_oe_o (oe)
    );

    function automatic logic [7:0] pat(input logic [12:0] a);
        return a[7:0] ^ {3'b000, a[12:8]} ^ 8'h5A;
    endfunction

    task automatic check_now(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: pairs observed items with queued expectations
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_val_q.size() > 0) begin
                check_now(exp_tag_q.pop_front(), act_q.pop_front(), exp_val_q.pop_front());
            end
        end
    end

    task automatic expect_item(input string tag, input int v);
        exp_tag_q.push_back(tag);
        exp_val_q.push_back(v);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        sda_m = 1'b0; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(Q);
        seen = sda_bus; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input string tag, input int exp_ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        expect_item(tag, exp_ack);
        act_q.push_back(int'(!s));
    endtask

    task automatic recv_byte(input string tag, input logic [7:0] exp_v, input logic mack);
        logic s;
        logic [7:0] v = '0;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, s);
            v = {v[6:0], s};
        end
        expect_item(tag, int'(exp_v));
        act_q.push_back(int'(v));
        clk_bit(!mack, s);
    endtask

    task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo);
        bus_start;
        send_byte(DEV_W, "R2 write id ack", 1);
        send_byte(hi, "R4 upper word ack", 1);
        send_byte(lo, "R4 lower word ack", 1);
    endtask

    task automatic read_run(input int n, input string tag);
        bus_start;
        send_byte(DEV_R, "R2 read id ack", 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(tag, pat(exp_addr), (i != n - 1));
            exp_addr = exp_addr + 1'b1;
        end
        bus_stop;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic s;
        tick(5);
        // R1: enable low in reset and just after
        check_now("R1 enable in reset", int'(oe), 0);
        rst_n = 1'b1;
        tick(10);
        check_now("R1 enable after reset", int'(oe), 0);

        // R5 R2 R4: random read at 0x0123
        set_addr(8'h01, 8'h23);
        exp_addr = 13'h0123;
        read_run(1, "R5 random read data");

        // R6: current-address read continues at 0x0124
        read_run(1, "R6 current read data");

        // R7: sequential run across the wrap point
        set_addr(8'h1F, 8'hFE);
        exp_addr = 13'h1FFE;
        read_run(3, "R7 sequential wrap data");
        read_run(1, "R7 read after wrap");

        // R4: top three bits of the upper byte are ignored
        set_addr(8'hE2, 8'h34);
        exp_addr = 13'h0234;
        read_run(1, "R4 dont-care upper bits");

        // R3: strap mismatch, then a matching byte without a new start
        bus_start;
        send_byte({4'b1010, 3'b001, 1'b1}, "R3 strap mismatch no ack", 0);
        send_byte(8'h00, "R3 ignored byte", 0);
        send_byte(DEV_R, "R3 late match ignored", 0);
        bus_stop;
        // R3: code mismatch with matching straps
        bus_start;
        send_byte({4'b1011, STRAP, 1'b1}, "R3 code mismatch no ack", 0);
        bus_stop;
        read_run(1, "R3 counter kept after mismatch");

        // R8: stop after only the upper word byte leaves counter alone
        bus_start;
        send_byte(DEV_W, "R8 id ack", 1);
        send_byte(8'h05, "R8 upper ack", 1);
        check_now("R8 release before stop", int'(oe), 0);
        bus_stop;
        read_run(1, "R8 counter kept after stop");

        // R8: repeated start in the middle of the upper byte
        bus_start;
        send_byte(DEV_W, "R8 id ack", 1);
        for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
        read_run(1, "R8 counter kept after restart");

        // R10 R9: write frame with a trailing data byte
        set_addr(8'h00, 8'h40);
        check_now("R9 ack released after ninth fall", int'(sda_bus), 1);
        send_byte(8'h77, "R10 data byte not acked", 0);
        bus_stop;
        exp_addr = 13'h0040;
        read_run(2, "R10 array unchanged, counter loaded");

        tick(20);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule